// File: doc/BRIEF.md
# Two-Level Interrupt Arbiter

This block sits between the event flags of a small controller's peripherals and its instruction sequencer. Eight request flags come in: two external lines, overflow of timers 0, 1 and 2, the external event of timer 2, and serial receive and transmit. The arbiter folds them into six sources. The two serial flags form one source, and so do the two timer-2 flags. Each source is masked by its own enable and by one global enable. Each source is also placed at one of two priority levels.

Each cycle the arbiter picks the most urgent eligible source. It presents a registered request with the source's fixed program-memory vector. When the core acknowledges, the arbiter marks the source's level as in service and returns clear pulses for the edge-type flags. A return from a handler releases the highest level in service. No new request is raised when the core reports the last cycle of an instruction or a handler return. No new request is raised while the enable or priority settings are being accessed, nor in the cycle after such an access.

Top module: `irq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no flags set, irq_o is 0, vec_o is 0000h, isr_o is 00 and clr_o is 00h.
- R2: Flag bits map to sources as follows: bit0 external 0 goes to source 0, bit2 timer 0 to source 1, bit1 external 1 to source 2, bit3 timer 1 to source 3, bits 6 and 7 (serial receive, transmit) to source 4, and bits 4 and 5 (timer-2 overflow, timer-2 external) to source 5.
- R3: A source takes part only when its bit in en_i and gen_i are both 1. With gen_i at 0, no request is raised.
- R4: The vector for source n is 0003h + 8*n, giving 0003h, 000Bh, 0013h, 001Bh, 0023h and 002Bh. vec_o reads 0000h while irq_o is 0.
- R5: A source whose prio_i bit is 1 wins over any source whose prio_i bit is 0. Within one level, the lowest source index wins.
- R6: irq_o and vec_o are registered. They reflect the inputs of the cycle before the clock edge.
- R7: No request is raised at an edge when last_cycle_i, reti_i or cfg_acc_i is 1 in that cycle. No request is raised at the edge that follows a cycle with cfg_acc_i at 1.
- R8: ack_i while irq_o is 1 sets isr_o bit 1 for a high-level grant or bit 0 for a low-level grant, and drives irq_o to 0 at that edge.
- R9: While isr_o[1] is 1, no request is raised. While only isr_o[0] is 1, only high-level sources can raise a request.
- R10: reti_i clears isr_o[1] if it is set, and otherwise clears isr_o[0].
- R11: In the acknowledge cycle, clr_o pulses bit 0, 1, 2 or 3 when the grant is external 0, external 1, timer 0 or timer 1. For serial and timer-2 grants, and outside acknowledge cycles, clr_o is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flags_i | input | 8 | Raw request flags (bit map in R2) |
| en_i | input | 6 | Per-source enables, indexed by source |
| gen_i | input | 1 | Global enable |
| prio_i | input | 6 | Per-source level, 1 = high |
| last_cycle_i | input | 1 | Core is in the final cycle of an instruction |
| reti_i | input | 1 | Core executes a return from handler |
| cfg_acc_i | input | 1 | Enable or priority settings are being accessed |
| ack_i | input | 1 | Core accepts the pending request |
| irq_o | output | 1 | Registered request to the core |
| vec_o | output | 16 | Vector address of the requested source |
| isr_o | output | 2 | In-service bits, [1] high level, [0] low level |
| clr_o | output | 8 | One-cycle clear pulses back to the flag sources |

## Verification
A change in flags, enables, priorities or blocking inputs shows up on irq_o and vec_o at the first rising edge after it. The bench therefore drives all inputs just after an edge and samples one edge later. clr_o is combinational from ack_i and the held grant, so it is checked in the same cycle that ack_i is driven, before the next edge. isr_o changes at the edge that takes ack_i or reti_i and is checked right after that edge. The one-cycle tail of a settings access is checked across two consecutive edges.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_FLAGS = 8;
  localparam int NUM_SRC   = 6;

  typedef enum logic [2:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4,
    SRC_TMR2 = 3'd5
  } src_e;

  // flag bit positions
  localparam int FL_EXT0 = 0;
  localparam int FL_EXT1 = 1;
  localparam int FL_TMR0 = 2;
  localparam int FL_TMR1 = 3;
  localparam int FL_T2OV = 4;
  localparam int FL_T2EX = 5;
  localparam int FL_RX   = 6;
  localparam int FL_TX   = 7;
endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
  import irq_pkg::*;
#(
  parameter int NF = NUM_FLAGS,
  parameter int NS = NUM_SRC
) (
  input  logic [NF-1:0] flags_i,
  input  logic [NS-1:0] en_i,
  input  logic          gen_i,
  output logic [NS-1:0] pend_o
);
  logic [NS-1:0] raw;

  always_comb begin
    raw           = '0;
    raw[SRC_EXT0] = flags_i[FL_EXT0];
    raw[SRC_TMR0] = flags_i[FL_TMR0];
    raw[SRC_EXT1] = flags_i[FL_EXT1];
    raw[SRC_TMR1] = flags_i[FL_TMR1];
    raw[SRC_SER]  = flags_i[FL_RX] | flags_i[FL_TX];
    raw[SRC_TMR2] = flags_i[FL_T2OV] | flags_i[FL_T2EX];
  end

  genvar g;
  generate
    for (g = 0; g < NS; g++) begin : g_mask
      assign pend_o[g] = raw[g] & en_i[g] & gen_i;
    end
  endgenerate
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int NS = 6,
  localparam int IW = $clog2(NS)
) (
  input  logic [NS-1:0] pend_i,
  input  logic [NS-1:0] prio_i,
  input  logic [1:0]    isr_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o,
  output logic          lvl_o
);
  logic [1:0]    lvl_hit;
  logic [IW-1:0] lvl_idx [2];

  genvar l;
  generate
    for (l = 0; l < 2; l++) begin : g_lvl
      logic [NS-1:0] cand;
      logic          allow;
      // high level blocked only by an active high handler, low by any
      assign allow = (l == 1) ? !isr_i[1] : (isr_i == 2'b00);
      assign cand  = pend_i & ((l == 1) ? prio_i : ~prio_i);

      always_comb begin
        lvl_hit[l] = allow & (|cand);
        lvl_idx[l] = '0;
        for (int i = NS - 1; i >= 0; i--) begin
          if (cand[i]) lvl_idx[l] = IW'(i);
        end
      end
    end
  endgenerate

  always_comb begin
    valid_o = |lvl_hit;
    lvl_o   = lvl_hit[1];
    idx_o   = lvl_hit[1] ? lvl_idx[1] : lvl_idx[0];
  end
endmodule

// File: rtl/irq_isr_track.sv
module irq_isr_track (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       take_i,
  input  logic       take_lvl_i,
  input  logic       ret_i,
  output logic [1:0] isr_o
);
  logic [1:0] isr_q, isr_d;

  always_comb begin
    isr_d = isr_q;
    if (ret_i) begin
      if (isr_q[1]) isr_d[1] = 1'b0;
      else          isr_d[0] = 1'b0;
    end
    if (take_i) isr_d[take_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= isr_d;
  end

  assign isr_o = isr_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int NF        = NUM_FLAGS,
  parameter int NS        = NUM_SRC,
  parameter int VW        = 16,
  parameter int VEC_BASE  = 3,
  parameter int VEC_STEP  = 8,
  localparam int IW       = $clog2(NS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] flags_i,
  input  logic [NS-1:0] en_i,
  input  logic          gen_i,
  input  logic [NS-1:0] prio_i,
  input  logic          last_cycle_i,
  input  logic          reti_i,
  input  logic          cfg_acc_i,
  input  logic          ack_i,
  output logic          irq_o,
  output logic [VW-1:0] vec_o,
  output logic [1:0]    isr_o,
  output logic [NF-1:0] clr_o
);
  logic [NS-1:0] pend;
  logic          sel_valid, sel_lvl;
  logic [IW-1:0] sel_idx;
  logic          irq_q, lvl_q, cfg_q;
  logic [IW-1:0] idx_q;
  logic          take, block;

  irq_src_map #(.NF(NF), .NS(NS)) u_map (
    .flags_i (flags_i),
    .en_i    (en_i),
    .gen_i   (gen_i),
    .pend_o  (pend)
  );

  irq_prio_sel #(.NS(NS)) u_sel (
    .pend_i  (pend),
    .prio_i  (prio_i),
    .isr_i   (isr_o),
    .valid_o (sel_valid),
    .idx_o   (sel_idx),
    .lvl_o   (sel_lvl)
  );

  irq_isr_track u_isr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .take_lvl_i (lvl_q),
    .ret_i      (reti_i),
    .isr_o      (isr_o)
  );

  assign take  = ack_i & irq_q;
  assign block = last_cycle_i | reti_i | cfg_acc_i | cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      idx_q <= '0;
      lvl_q <= 1'b0;
      cfg_q <= 1'b0;
    end else begin
      cfg_q <= cfg_acc_i;
      irq_q <= sel_valid & ~block & ~take;
      if (sel_valid) begin
        idx_q <= sel_idx;
        lvl_q <= sel_lvl;
      end
    end
  end

  assign irq_o = irq_q;
  assign vec_o = irq_q ? (VW'(VEC_BASE) + VW'(idx_q) * VW'(VEC_STEP)) : '0;

  // edge-type flags are cleared by hardware, serial and timer 2 by software
  always_comb begin
    clr_o = '0;
    if (take) begin
      case (idx_q)
        IW'(SRC_EXT0): clr_o[FL_EXT0] = 1'b1;
        IW'(SRC_EXT1): clr_o[FL_EXT1] = 1'b1;
        IW'(SRC_TMR0): clr_o[FL_TMR0] = 1'b1;
        IW'(SRC_TMR1): clr_o[FL_TMR1] = 1'b1;
        default:       clr_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NF = 8,
  parameter int VW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          last_cycle_i,
  input logic          reti_i,
  input logic          cfg_acc_i,
  input logic          ack_i,
  input logic          irq_o,
  input logic [VW-1:0] vec_o,
  input logic [1:0]    isr_o,
  input logic [NF-1:0] clr_o
);
  a_r7_block_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_cycle_i || reti_i || cfg_acc_i) |=> !irq_o);

  a_r7_block_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_acc_i |=> !irq_o ##1 !irq_o);

  a_r8_ack_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> !irq_o);

  a_r8_ack_sets_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !reti_i) |=> (isr_o != 2'b00));

  a_r9_high_active_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_o[1] |=> !irq_o);

  a_r10_reti_clears_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && isr_o[1] && !ack_i) |=> !isr_o[1]);

  a_r11_clr_only_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_o != '0) |-> (ack_i && irq_o && $onehot0(clr_o) && clr_o[NF-1:4] == '0));

  a_r4_vec_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o[2:0] == 3'b011 && vec_o <= VW'(16'h002B)));
endmodule

bind irq_ctrl irq_ctrl_chk #(.NF(NF), .VW(VW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .last_cycle_i (last_cycle_i),
  .reti_i       (reti_i),
  .cfg_acc_i    (cfg_acc_i),
  .ack_i        (ack_i),
  .irq_o        (irq_o),
  .vec_o        (vec_o),
  .isr_o        (isr_o),
  .clr_o        (clr_o)
);

// File: tb/irq_ctrl_tb.sv
`timescale 1ns/1ps
module irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  flags = '0;
  logic [5:0]  en = '0;
  logic        gen = 1'b0;
  logic [5:0]  prio = '0;
  logic        last_c = 1'b0, reti = 1'b0, cfg = 1'b0, ack = 1'b0;
  logic        irq;
  logic [15:0] vec;
  logic [1:0]  isr;
  logic [7:0]  clr;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flags_i(flags), .en_i(en), .gen_i(gen),
    .prio_i(prio), .last_cycle_i(last_c), .reti_i(reti), .cfg_acc_i(cfg),
    .ack_i(ack), .irq_o(irq), .vec_o(vec), .isr_o(isr), .clr_o(clr)
  );

  // {flags, en, gen, prio, exp_irq, exp_vec}
  localparam int NV = 11;
  localparam logic [37:0] TBL [NV] = '{
    {8'h01, 6'h3F, 1'b1, 6'h00, 1'b1, 16'h0003},  // R2 R4 ext0
    {8'h04, 6'h3F, 1'b1, 6'h00, 1'b1, 16'h000B},  // R2 R4 timer0
    {8'h80, 6'h3F, 1'b1, 6'h00, 1'b1, 16'h0023},  // R2 tx -> serial
    {8'h10, 6'h3F, 1'b1, 6'h00, 1'b1, 16'h002B},  // R2 t2 overflow
    {8'h20, 6'h3F, 1'b1, 6'h00, 1'b1, 16'h002B},  // R2 t2 external
    {8'h0F, 6'h3F, 1'b1, 6'h00, 1'b1, 16'h0003},  // R5 in-level order
    {8'h0F, 6'h3F, 1'b1, 6'h08, 1'b1, 16'h001B},  // R5 high wins
    {8'hFF, 6'h3F, 1'b0, 6'h00, 1'b0, 16'h0000},  // R3 global off
    {8'h01, 6'h3E, 1'b1, 6'h00, 1'b0, 16'h0000},  // R3 local off
    {8'h41, 6'h3F, 1'b1, 6'h10, 1'b1, 16'h0023},  // R5 serial high
    {8'h06, 6'h3F, 1'b1, 6'h00, 1'b1, 16'h000B}   // R5 timer0 before ext1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #12;
    check("R1 irq", irq, 0);
    check("R1 isr", isr, 0);
    rst_n = 1'b1;
    tick();
    check("R1 irq idle", irq, 0);
    check("R1 vec idle", vec, 0);
    check("R1 clr idle", clr, 0);

    for (int i = 0; i < NV; i++) begin
      {flags, en, gen, prio} = TBL[i][37:17];
      tick();
      check($sformatf("R6 table %0d irq", i), irq, TBL[i][16]);
      check($sformatf("R4 table %0d vec", i), vec, TBL[i][15:0]);
      flags = '0; en = '0; gen = 1'b0; prio = '0;
      tick();
      check("R4 vec zero when idle", vec, 0);
    end

    // nesting: low ext0 granted
    en = 6'h3F; gen = 1'b1; flags = 8'h01;
    tick();
    check("R6 ext0 irq", irq, 1);
    ack = 1'b1; #1;
    check("R11 ext0 clear", clr, 8'h01);
    tick();
    ack = 1'b0; flags = 8'h00;
    check("R8 low isr", isr, 2'b01);
    check("R8 irq dropped", irq, 0);
    flags = 8'h04;  // timer0 low
    tick();
    check("R9 low held", irq, 0);
    flags = 8'h06; prio = 6'h04;  // ext1 high
    tick();
    check("R9 high preempts", irq, 1);
    check("R4 ext1 vec", vec, 16'h0013);
    ack = 1'b1; #1;
    check("R11 ext1 clear", clr, 8'h02);
    tick();
    ack = 1'b0; flags = 8'h04;
    check("R8 high isr", isr, 2'b11);
    flags = 8'h44; prio = 6'h14;  // rx high
    tick();
    check("R9 high active blocks", irq, 0);
    reti = 1'b1;
    tick();
    reti = 1'b0;
    check("R10 high cleared", isr, 2'b01);
    check("R7 reti blocks", irq, 0);
    tick();
    check("R9 serial high", vec, 16'h0023);
    ack = 1'b1; #1;
    check("R11 serial not cleared", clr, 8'h00);
    tick();
    ack = 1'b0; flags = 8'h04;
    check("R8 serial isr", isr, 2'b11);
    reti = 1'b1;
    tick();
    check("R10 first return", isr, 2'b01);
    tick();
    reti = 1'b0;
    check("R10 low cleared", isr, 2'b00);
    check("R7 reti blocks low", irq, 0);
    tick();
    check("R9 low resumes", vec, 16'h000B);
    flags = '0; prio = '0;
    tick();

    // blocking conditions
    flags = 8'h01; last_c = 1'b1;
    tick();
    check("R7 last cycle", irq, 0);
    last_c = 1'b0;
    tick();
    check("R7 after last cycle", irq, 1);
    flags = '0;
    tick();
    flags = 8'h01; cfg = 1'b1;
    tick();
    check("R7 cfg access", irq, 0);
    cfg = 1'b0;
    tick();
    check("R7 cfg tail", irq, 0);
    tick();
    check("R7 cfg released", irq, 1);
    flags = '0;
    tick();
    check("R1 final idle", irq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule